// File: doc/BRIEF.md
# Cell-Slave Receive Port

This block is the receive half of a slave on a shared, byte-wide cell bus. A bus master clocks fixed-length 53-byte cells into it, one byte per clock. The first byte of each cell is flagged with a start-of-cell input. Several slaves share the bus, and a 5-bit address picks one of them. Address 31 is reserved as a null address that selects nobody. The slave drives a shared space-available line. It drives this line only while the bus address equals its own configured address; at all other times the line is left floating.

Incoming bytes are assembled directly into a two-cell buffer. A cell becomes visible to the local side only once all 53 bytes have landed. If a start-of-cell arrives part-way through a cell, the partial cell is dropped, a runt counter steps by one (it wraps), and reception restarts with the new cell. The local side drains whole cells through a valid/ready byte stream that marks each cell's first byte. Back-pressure rule: a byte transfers on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the presented byte and its marker hold still. `rd_valid` never drops until the byte has transferred.

Top module: `cell_rx_port`

## Requirements
- R1: After reset, `rd_valid` is 0, `runt_count` is 0, and the space flag reads 1 when addressed.
- R2: A byte and its start flag are captured on the clock edge after one where `bus_enb` was 1 and `bus_addr` equalled `own_addr`. Bytes in any other cycle have no effect.
- R3: A cell is offered on the read port only after all 53 of its bytes were captured. A cell that has received 52 bytes or fewer leaves `rd_valid` at 0.
- R4: Stored cells leave in arrival order, byte order preserved, with `rd_soc`=1 exactly on each cell's first byte. While `rd_valid`=1 and `rd_ready`=0, `rd_valid`, `rd_data` and `rd_soc` stay unchanged.
- R5: A captured start flag while a cell is partly received discards that partial cell, adds 1 to `runt_count`, and starts a new cell with the current byte.
- R6: The space flag is 1 when fewer than two complete cells are stored and 0 when two are stored.
- R7: `space_avail` is high impedance unless `bus_addr` equals `own_addr` and `own_addr` is not 31. An own address of 31 never captures bytes.
- R8: A cell whose start flag is captured while two cells are stored is dropped whole, and so are its later bytes. Stored cells are unaffected.
- R9: Captured bytes without a preceding start flag, outside a cell, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the master |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_enb | input | 1 | Master enable, active high |
| bus_soc | input | 1 | Start-of-cell flag for the current byte |
| bus_data | input | 8 | Cell byte |
| bus_addr | input | 5 | Slave select address |
| own_addr | input | 5 | Configured address of this slave |
| space_avail | output | 1 | Room for a complete cell; tristate |
| runt_count | output | 8 | Wrapping count of discarded partial cells |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| rd_soc | output | 1 | Read stream first-byte marker |

## Verification
The bench targets the cycle offset between enable and data. A design that samples in the enable cycle itself would take in idle noise bytes and shift every cell. It also sends 52-byte cells, runts of every length, and a third cell offered while the buffer is full. A wrong commit point would release short cells, a missed restart would splice two cells together, and a missed full check would overwrite stored data. Random read stalls catch a stream that changes its byte while held. Checks of the floating line under foreign, null and matching addresses catch a slave that fights another on the shared flag.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
  typedef enum logic {
    ASM_IDLE = 1'b0,
    ASM_FILL = 1'b1
  } asm_state_t;

  localparam int unsigned CELL_BYTES_DEF = 53;
  localparam int unsigned DEPTH_DEF      = 2;
endpackage

// File: rtl/cell_rx_assembler.sv
module cell_rx_assembler
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = CELL_BYTES_DEF,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RUNT_W     = 8,
  localparam int unsigned IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic              has_room,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [RUNT_W-1:0] runt_count
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  asm_state_t         state;
  logic [IDX_W-1:0]   idx;

  assign wr_data = data;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = idx;
    commit = 1'b0;
    if (sel) begin
      if (soc) begin
        wr_en  = has_room;
        wr_idx = '0;
      end else if (state == ASM_FILL) begin
        wr_en  = 1'b1;
        commit = (idx == LAST_IDX);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ASM_IDLE;
      idx        <= '0;
      runt_count <= '0;
    end else if (sel) begin
      if (soc) begin
        if (state == ASM_FILL) runt_count <= runt_count + 1'b1;
        if (has_room) begin
          state <= ASM_FILL;
          idx   <= IDX_W'(1);
        end else begin
          state <= ASM_IDLE;
          idx   <= '0;
        end
      end else if (state == ASM_FILL) begin
        if (idx == LAST_IDX) begin
          state <= ASM_IDLE;
          idx   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R5: a restart inside a cell bumps the runt counter by exactly one
  a_r5_runt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && soc && state == ASM_FILL) |=> runt_count == $past(runt_count) + 1'b1);

  // R9: nothing is written while no cell is open and no start flag is present
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ASM_IDLE && !soc) |-> !wr_en);
endmodule

// File: rtl/cell_rx_store.sv
module cell_rx_store
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = CELL_BYTES_DEF,
  parameter int unsigned DEPTH      = DEPTH_DEF,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned IDX_W     = $clog2(CELL_BYTES),
  localparam int unsigned TOTAL     = CELL_BYTES * DEPTH,
  localparam int unsigned MEM_AW    = $clog2(TOTAL),
  localparam int unsigned SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic              has_room,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [TOTAL];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  count;
  logic [MEM_AW-1:0] wr_addr, rd_addr;
  logic              pop_last;

  assign wr_addr  = MEM_AW'(wr_slot) * MEM_AW'(CELL_BYTES) + MEM_AW'(wr_idx);
  assign rd_addr  = MEM_AW'(rd_slot) * MEM_AW'(CELL_BYTES) + MEM_AW'(rd_idx);
  assign has_room = (count < FULL_CNT);
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_addr];
  assign rd_soc   = (rd_idx == '0);
  assign pop_last = rd_valid && rd_ready && (rd_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= '0;
      rd_slot <= '0;
      rd_idx  <= '0;
      count   <= '0;
    end else begin
      if (commit) wr_slot <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
      if (rd_valid && rd_ready) begin
        if (rd_idx == LAST_IDX) begin
          rd_idx  <= '0;
          rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
      case ({commit, pop_last})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: stored cells never exceed the buffer depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8: a cell is never completed into a full buffer
  a_r8_commit_room: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> count < FULL_CNT);

  // R4: a stalled byte holds still
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_soc)));
endmodule

// File: rtl/cell_rx_port.sv
module cell_rx_port
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = CELL_BYTES_DEF,
  parameter int unsigned DEPTH      = DEPTH_DEF,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned RUNT_W     = 8,
  localparam int unsigned IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_enb,
  input  logic              bus_soc,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              space_avail,
  output logic [RUNT_W-1:0] runt_count,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  logic              addressed;
  logic              sel_q;
  logic              has_room;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              commit;

  assign addressed   = (bus_addr == own_addr) && (own_addr != NULL_ADDR);
  assign space_avail = addressed ? has_room : 1'bz;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= bus_enb && addressed;
  end

  cell_rx_assembler #(
    .CELL_BYTES (CELL_BYTES),
    .DATA_W     (DATA_W),
    .RUNT_W     (RUNT_W)
  ) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel_q),
    .soc        (bus_soc),
    .data       (bus_data),
    .has_room   (has_room),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .commit     (commit),
    .runt_count (runt_count)
  );

  cell_rx_store #(
    .CELL_BYTES (CELL_BYTES),
    .DEPTH      (DEPTH),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .commit   (commit),
    .has_room (has_room),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_soc   (rd_soc)
  );

  // R2: a capture cycle always follows an enabled cycle
  a_r2_capture_after_enb: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> $past(bus_enb));

  // R7: the null address never leads to a capture
  a_r7_null_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (own_addr == NULL_ADDR && $stable(own_addr)) |=> !sel_q);
endmodule

// File: tb/cell_rx_port_bench.sv
module cell_rx_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 53;
  localparam int MAXS = 1024;
  localparam logic [4:0] OWN = 5'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_enb = 1'b0, bus_soc = 1'b0, rd_ready = 1'b0;
  logic [7:0] bus_data = '0;
  logic [4:0] bus_addr = 5'd31, own_addr = OWN;
  wire        space_avail;
  logic [7:0] runt_count, rd_data;
  logic       rd_valid, rd_soc;

  int errors = 0, checks = 0;

  logic       s_en   [MAXS];
  logic [4:0] s_addr [MAXS];
  logic [7:0] s_data [MAXS];
  logic       s_soc  [MAXS];
  int         ns = 0;

  bit         m_in = 0;
  int         m_idx = 0, m_cnt = 0;
  logic [7:0] m_runt = '0;
  logic [7:0] cur [CELL];
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_rx_port u_cell_rx_port (
    .clk(clk), .rst_n(rst_n), .bus_enb(bus_enb), .bus_soc(bus_soc),
    .bus_data(bus_data), .bus_addr(bus_addr), .own_addr(own_addr),
    .space_avail(space_avail), .runt_count(runt_count),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_soc(rd_soc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void m_byte(input logic [7:0] d, input logic s);
    if (s) begin
      if (m_in) m_runt = m_runt + 8'd1;
      if (m_cnt < 2) begin m_in = 1; cur[0] = d; m_idx = 1; end
      else begin m_in = 0; m_idx = 0; end
    end else if (m_in) begin
      cur[m_idx] = d;
      if (m_idx == CELL - 1) begin
        for (int k = 0; k < CELL; k++) exp_q.push_back(cur[k]);
        m_cnt++; m_in = 0; m_idx = 0;
      end else m_idx++;
    end
  endfunction

  task automatic add_sel(input logic [7:0] d, input logic s);
    if (ns < MAXS) begin
      s_en[ns] = 1; s_addr[ns] = OWN; s_data[ns] = d; s_soc[ns] = s; ns++;
      m_byte(d, s);
    end
  endtask

  task automatic add_noise();
    if (ns < MAXS) begin
      s_en[ns] = $urandom % 2;
      s_addr[ns] = 5'($urandom);
      if (s_addr[ns] == OWN) s_addr[ns] = (s_en[ns]) ? 5'd31 : OWN;
      if (s_en[ns] == 0) s_addr[ns] = OWN;
      s_data[ns] = 8'($urandom); s_soc[ns] = $urandom % 2; ns++;
    end
  endtask

  task automatic add_cell(input int len);
    for (int k = 0; k < len; k++) begin
      add_sel(8'($urandom), k == 0);
      if ($urandom % 6 == 0) add_noise();
    end
  endtask

  task automatic play();
    @(negedge clk);
    bus_enb = (ns > 0) ? s_en[0] : 1'b0;
    bus_addr = (ns > 0) ? s_addr[0] : OWN;
    for (int i = 0; i < ns; i++) begin
      @(negedge clk);
      bus_data = s_data[i]; bus_soc = s_soc[i];
      if (i + 1 < ns) begin bus_enb = s_en[i+1]; bus_addr = s_addr[i+1]; end
      else begin bus_enb = 0; bus_addr = OWN; end
    end
    @(negedge clk);
    bus_soc = 0; bus_data = '0; bus_addr = OWN;
    ns = 0;
  endtask

  task automatic check_state(input string tag);
    @(negedge clk);
    bus_addr = OWN; #1;
    chk(space_avail === (m_cnt < 2), {"R6 space ", tag}, 32'(space_avail), 32'(m_cnt < 2));
    chk(runt_count == m_runt, {"R5 runt ", tag}, 32'(runt_count), 32'(m_runt));
    chk(rd_valid == (m_cnt > 0), {"R3 valid ", tag}, 32'(rd_valid), 32'(m_cnt > 0));
  endtask

  task automatic drain(input int ready_pct);
    int pos = 0, guard = 0;
    bit stalled = 0, v, r;
    logic [7:0] held = '0;
    logic hs = 0;
    while (exp_q.size() > 0 && guard < 5000) begin
      guard++;
      @(negedge clk);
      chk(rd_valid == 1, "R4 valid during drain", 32'(rd_valid), 1);
      if (rd_valid) begin
        chk(rd_data == exp_q[0], "R4 data order", 32'(rd_data), 32'(exp_q[0]));
        chk(rd_soc == (pos == 0), "R4 soc marker", 32'(rd_soc), 32'(pos == 0));
        if (stalled) chk(rd_data == held && rd_soc == hs, "R4 stall hold", 32'(rd_data), 32'(held));
      end
      held = rd_data; hs = rd_soc;
      rd_ready = (int'($urandom % 100) < ready_pct);
      v = rd_valid; r = rd_ready;
      @(posedge clk);
      if (v && r) begin void'(exp_q.pop_front()); pos = (pos + 1) % CELL; end
      stalled = v && !r;
    end
    @(negedge clk);
    rd_ready = 0;
    m_cnt = 0;
    chk(rd_valid == 0, "R4 empty after drain", 32'(rd_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    bus_addr = OWN;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_state("R1 reset");

    // R9: stray bytes with no start flag
    for (int k = 0; k < 6; k++) add_sel(8'(k + 1), 1'b0);
    play(); check_state("R9 stray");

    // R2: idle cycles carrying start flags and data must be ignored
    for (int k = 0; k < 8; k++) add_noise();
    play(); check_state("R2 noise");

    // R3: 52 bytes only, no release
    add_cell(CELL - 1);
    play(); check_state("R3 short");
    // R5: next cell restarts, short one becomes a runt
    add_cell(CELL);
    play(); check_state("R5 restart");
    drain(60);

    // R8 / R6: three cells into a two-cell buffer
    add_cell(CELL); add_cell(CELL); add_cell(CELL);
    play(); check_state("R8 full");
    chk(m_cnt == 2 && exp_q.size() == 2 * CELL, "R8 model depth", 32'(m_cnt), 2);
    drain(50);

    // R7: tristate behaviour
    @(negedge clk); bus_addr = 5'd3; #1;
    chk(space_avail === 1'bz, "R7 foreign addr z", 32'(space_avail), 0);
    bus_addr = 5'd31; #1;
    chk(space_avail === 1'bz, "R7 null bus addr z", 32'(space_avail), 0);
    own_addr = 5'd31; #1;
    chk(space_avail === 1'bz, "R7 null own addr z", 32'(space_avail), 0);
    bus_addr = 5'd31; bus_enb = 1; bus_soc = 1;
    repeat (CELL + 2) @(negedge clk);
    bus_enb = 0; bus_soc = 0;
    @(negedge clk);
    chk(rd_valid == 0 && runt_count == m_runt, "R7 null own no capture", 32'(rd_valid), 0);
    own_addr = OWN; bus_addr = OWN; #1;
    chk(space_avail === 1'b1, "R7 driven when addressed", 32'(space_avail), 1);

    // random bursts with runts, noise and back-pressure
    for (int b = 0; b < 30; b++) begin
      int n = 1 + ($urandom % 3);
      for (int c = 0; c < n; c++) begin
        int len = ($urandom % 3 == 0) ? 1 + int'($urandom % (CELL - 1)) : CELL;
        if ($urandom % 5 == 0) add_noise();
        add_cell(len);
      end
      play(); check_state("R2 random burst");
      drain(30 + int'($urandom % 70));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule